// File: doc/BRIEF.md
# Ethernet Bring-Up Self-Test Sequencer

This controller takes an Ethernet MAC+PCS datapath out of reset and then proves it with a short traffic run. It holds the datapath's active-low global reset low until the datapath acknowledges. It then releases reset and waits for the transmit lanes to report stable. Only after that does it wait for the receive PCS to report ready. From then on it drives a 32-bit memory-mapped master port. Over that port it starts the on-chip packet client and polls the transmit end-of-packet counter until the expected number of packets has gone out.

With traffic done, the sequencer freezes the statistics by setting a snapshot bit in the client's control word. It reads the six receive words and the six transmit words, then clears the snapshot bit. A single control write stops the client and clears the counters. The last step writes a pattern to a scratch word and reads it back. The result is a sticky `done` flag, a `pass` flag and a 3-bit code that names the first step that went wrong.

Each waiting step is bounded by a cycle limit taken from an input port. The master port issues one transaction at a time and holds each request steady until the bus stops asserting wait-request. Reads return data in the cycle the request is accepted.

Top module: `eth_bist_seq`

## Requirements
- R1: After the block's reset is released, `dp_rst_n` is 0. It rises only in the cycle after `dp_rst_ack_n` has been sampled 0. No bus request is issued while `dp_rst_n` is 0.
- R2: After `dp_rst_n` rises, the block waits for `tx_lanes_stable` = 1 and only then for `rx_pcs_ready` = 1. While `tx_lanes_stable` stays 0, no bus transaction is issued, even if `rx_pcs_ready` is 1.
- R3: The first bus access is a write of 0x0000_0001 to address 0x000. It is followed by reads of address 0x028 (transmit end-of-packet count, low word), repeated until the value read is at least PKT_COUNT.
- R4: Before the statistics reads, the block writes 0x0000_0041 to address 0x000 (bit 6 is snapshot, bit 0 is run). It then reads 0x038, 0x03C, 0x040, 0x044, 0x048 and 0x04C, followed by 0x020 through 0x034 in steps of 4. Afterwards it writes 0x0000_0001 to address 0x000. No statistics word other than 0x028 is read while snapshot is off.
- R5: Within each group of six words, the words at offsets +0 and +8 (start and end of packet, low word) must equal PKT_COUNT, and the other four words must be 0. Any other value sets error code 5 (statistics). The sequence still continues to its end.
- R6: After the snapshot is closed, the block writes 0x0000_0100 to address 0x000. This stops the client and clears its counters in one access.
- R7: The block writes SCRATCH_PAT to address 0x104 and reads it back. A difference sets error code 6 (scratch). `done` follows this read.
- R8: A step ends with `done` and a failure code if it waits `timeout_limit` cycles without completing. The codes are 1 for the reset acknowledge, 2 for TX lanes, 3 for RX PCS, 4 for the polling step, and 7 for a bus access that is not accepted.
- R9: At most one bus transaction is outstanding. `m_read` and `m_write` are never both 1. While wait-request is 1, the address, write data and strobes stay unchanged.
- R10: `done` stays 1 once set, until reset. `pass` is 1 exactly when `done` is 1 and the error code is 0. The first error code recorded is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| timeout_limit | input | TW | Cycle limit for every waiting step |
| dp_rst_n | output | 1 | Active-low global reset to the datapath |
| dp_rst_ack_n | input | 1 | Active-low reset acknowledge from the datapath |
| tx_lanes_stable | input | 1 | Transmit lanes stable status |
| rx_pcs_ready | input | 1 | Receive PCS ready status |
| m_address | output | AW | Master byte address |
| m_read | output | 1 | Master read strobe |
| m_write | output | 1 | Master write strobe |
| m_writedata | output | DW | Master write data |
| m_readdata | input | DW | Read data, valid when a read is accepted |
| m_waitrequest | input | 1 | Bus stall; a request is accepted in a cycle where it is 0 |
| done | output | 1 | Sequence finished |
| pass | output | 1 | Self-test passed |
| err_code | output | 3 | First failure code (0 none) |

## Verification
The assertions check on every cycle that the bus request stays steady under wait-request and that read and write never overlap. They also check that the datapath reset is only released after the acknowledge was seen, that statistics words are only read while the snapshot flag is set, and that the done flag and the first error code never change once set. Other properties need stimulus and can only be shown by the bench's scenarios. These are the exact order and values of the control writes, the RX-before-TX order of the statistics reads, and the wait for TX lanes before RX readiness. The scenarios also show the error code picked for each stalled step, counts that are short or carry errors, and a corrupted scratch read. The scenarios are swept across bus stall depths.

// File: rtl/eth_bist_pkg.sv
package eth_bist_pkg;

  typedef enum logic [3:0] {
    ST_RST, ST_WTX, ST_WRX, ST_START, ST_POLL, ST_SNAP_ON, ST_STATS,
    ST_SNAP_OFF, ST_STOP, ST_SCR_WR, ST_SCR_RD, ST_DONE
  } seq_state_t;

  typedef enum logic [2:0] {
    E_NONE = 3'd0, E_RSTACK = 3'd1, E_TXLANE = 3'd2, E_RXPCS = 3'd3,
    E_TRAFFIC = 3'd4, E_STATS = 3'd5, E_SCRATCH = 3'd6, E_BUS = 3'd7
  } seq_err_t;

  localparam int STAT_PER_DIR = 6;
  localparam int STAT_WORDS   = 2 * STAT_PER_DIR;
  localparam int STAT_IW      = $clog2(STAT_WORDS);

  localparam logic [11:0] A_CTRL      = 12'h000;
  localparam logic [11:0] A_TX_BASE   = 12'h020;
  localparam logic [11:0] A_TX_EOP_LO = 12'h028;
  localparam logic [11:0] A_RX_BASE   = 12'h038;
  localparam logic [11:0] A_STAT_LAST = 12'h04C;
  localparam logic [11:0] A_SCRATCH   = 12'h104;

  localparam logic [31:0] C_RUN      = 32'h0000_0001;
  localparam logic [31:0] C_SNAP     = 32'h0000_0041;
  localparam logic [31:0] C_STOP_CLR = 32'h0000_0100;

  // position of a read index inside its six-word group
  function automatic logic [STAT_IW-1:0] stat_pos(input logic [STAT_IW-1:0] idx);
    if (idx < STAT_IW'(STAT_PER_DIR)) return idx;
    return idx - STAT_IW'(STAT_PER_DIR);
  endfunction

  // receive group first, then transmit group
  function automatic logic [11:0] stat_addr(input logic [STAT_IW-1:0] idx);
    logic [11:0] base;
    base = (idx < STAT_IW'(STAT_PER_DIR)) ? A_RX_BASE : A_TX_BASE;
    return base + (12'(stat_pos(idx)) << 2);
  endfunction

  function automatic logic [31:0] stat_expect(input logic [STAT_IW-1:0] idx,
                                              input logic [31:0] pkt);
    logic [STAT_IW-1:0] p;
    p = stat_pos(idx);
    return (p == STAT_IW'(0) || p == STAT_IW'(2)) ? pkt : 32'd0;
  endfunction

endpackage

// File: rtl/eth_bist_timer.sv
module eth_bist_timer #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          en,
  input  logic [TW-1:0] limit,
  output logic          expired
);

  logic [TW-1:0] cnt_q;
  logic [TW-1:0] cnt_n;
  logic          cnt_en;

  assign expired = (cnt_q >= limit);

  always_comb begin
    cnt_en = clr || (en && !expired);
    cnt_n  = clr ? '0 : cnt_q + TW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_n;
  end

endmodule

// File: rtl/eth_bist_mm_master.sv
module eth_bist_mm_master #(
  parameter int AW = 12,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic          go_wr,
  input  logic [AW-1:0] go_addr,
  input  logic [DW-1:0] go_wdata,
  output logic          rsp_done,
  output logic [DW-1:0] rsp_data,
  output logic [AW-1:0] m_address,
  output logic          m_read,
  output logic          m_write,
  output logic [DW-1:0] m_writedata,
  input  logic [DW-1:0] m_readdata,
  input  logic          m_waitrequest
);

  logic          busy_q, wr_q, done_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q, data_q;
  logic          load, accept, busy_n;

  always_comb begin
    load   = !busy_q && go;
    accept = busy_q && !m_waitrequest;
    busy_n = load ? 1'b1 : (accept ? 1'b0 : busy_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      busy_q <= busy_n;
      done_q <= accept;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (load) begin
      wr_q    <= go_wr;
      addr_q  <= go_addr;
      wdata_q <= go_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 data_q <= '0;
    else if (accept && !wr_q)   data_q <= m_readdata;
  end

  assign m_read      = busy_q && !wr_q;
  assign m_write     = busy_q && wr_q;
  assign m_address   = addr_q;
  assign m_writedata = wdata_q;
  assign rsp_done    = done_q;
  assign rsp_data    = data_q;

  // R9
  hold_under_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (m_read || m_write) && m_waitrequest |=>
      $stable(m_address) && $stable(m_writedata) && $stable(m_read) && $stable(m_write));

  // R9
  no_rd_wr_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({m_read, m_write}));

  // R9
  single_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> !(m_read || m_write));

endmodule

// File: rtl/eth_bist_seq.sv
module eth_bist_seq
  import eth_bist_pkg::*;
#(
  parameter int          AW          = 12,
  parameter int          DW          = 32,
  parameter int          TW          = 16,
  parameter int          PKT_COUNT   = 16,
  parameter logic [31:0] SCRATCH_PAT = 32'hA5C3_5A3C
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [TW-1:0] timeout_limit,
  output logic          dp_rst_n,
  input  logic          dp_rst_ack_n,
  input  logic          tx_lanes_stable,
  input  logic          rx_pcs_ready,
  output logic [AW-1:0] m_address,
  output logic          m_read,
  output logic          m_write,
  output logic [DW-1:0] m_writedata,
  input  logic [DW-1:0] m_readdata,
  input  logic          m_waitrequest,
  output logic          done,
  output logic          pass,
  output logic [2:0]    err_code
);

  localparam logic [DW-1:0] PKT_W = DW'(PKT_COUNT);

  // reset: asynchronous assert, synchronous release
  logic [1:0] rs_q;
  logic       srst_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign srst_n = rs_q[1];

  seq_state_t         st_q, st_n;
  seq_err_t           err_q, err_val;
  logic               pend_q, pend_n, snap_q, snap_n, rel_q, rel_n, err_set;
  logic [STAT_IW-1:0] idx_q, idx_n;
  logic               go, go_wr;
  logic [AW-1:0]      go_addr;
  logic [DW-1:0]      go_wdata;
  logic               rsp_done;
  logic [DW-1:0]      rsp_data;
  logic               tmr_clr, tmr_en, tmr_exp;

  eth_bist_mm_master #(.AW(AW), .DW(DW)) u_master (
    .clk(clk), .rst_n(srst_n), .go(go), .go_wr(go_wr), .go_addr(go_addr),
    .go_wdata(go_wdata), .rsp_done(rsp_done), .rsp_data(rsp_data),
    .m_address(m_address), .m_read(m_read), .m_write(m_write),
    .m_writedata(m_writedata), .m_readdata(m_readdata),
    .m_waitrequest(m_waitrequest)
  );

  eth_bist_timer #(.TW(TW)) u_timer (
    .clk(clk), .rst_n(srst_n), .clr(tmr_clr), .en(tmr_en),
    .limit(timeout_limit), .expired(tmr_exp)
  );

  // command carried by each bus step
  always_comb begin
    go_wr    = 1'b0;
    go_addr  = '0;
    go_wdata = '0;
    case (st_q)
      ST_START:    begin go_wr = 1'b1; go_addr = AW'(A_CTRL); go_wdata = DW'(C_RUN); end
      ST_POLL:     go_addr = AW'(A_TX_EOP_LO);
      ST_SNAP_ON:  begin go_wr = 1'b1; go_addr = AW'(A_CTRL); go_wdata = DW'(C_SNAP); end
      ST_STATS:    go_addr = AW'(stat_addr(idx_q));
      ST_SNAP_OFF: begin go_wr = 1'b1; go_addr = AW'(A_CTRL); go_wdata = DW'(C_RUN); end
      ST_STOP:     begin go_wr = 1'b1; go_addr = AW'(A_CTRL); go_wdata = DW'(C_STOP_CLR); end
      ST_SCR_WR:   begin go_wr = 1'b1; go_addr = AW'(A_SCRATCH); go_wdata = DW'(SCRATCH_PAT); end
      ST_SCR_RD:   go_addr = AW'(A_SCRATCH);
      default:     ;
    endcase
  end

  // next state
  always_comb begin
    st_n    = st_q;
    pend_n  = pend_q;
    idx_n   = idx_q;
    snap_n  = snap_q;
    rel_n   = rel_q;
    err_set = 1'b0;
    err_val = E_NONE;
    go      = 1'b0;
    tmr_en  = 1'b0;
    case (st_q)
      ST_RST: begin
        tmr_en = 1'b1;
        if (!dp_rst_ack_n) begin rel_n = 1'b1; st_n = ST_WTX; end
        else if (tmr_exp)  begin err_set = 1'b1; err_val = E_RSTACK; st_n = ST_DONE; end
      end
      ST_WTX: begin
        tmr_en = 1'b1;
        if (tx_lanes_stable) st_n = ST_WRX;
        else if (tmr_exp)    begin err_set = 1'b1; err_val = E_TXLANE; st_n = ST_DONE; end
      end
      ST_WRX: begin
        tmr_en = 1'b1;
        if (rx_pcs_ready)  st_n = ST_START;
        else if (tmr_exp)  begin err_set = 1'b1; err_val = E_RXPCS; st_n = ST_DONE; end
      end
      ST_DONE: ;
      default: begin
        tmr_en = 1'b1;
        if (rsp_done) begin
          pend_n = 1'b0;
          case (st_q)
            ST_START:    st_n = ST_POLL;
            ST_POLL:     if (rsp_data >= PKT_W) st_n = ST_SNAP_ON;
            ST_SNAP_ON:  begin snap_n = 1'b1; idx_n = '0; st_n = ST_STATS; end
            ST_STATS: begin
              if (rsp_data != DW'(stat_expect(idx_q, 32'(PKT_COUNT)))) begin
                err_set = 1'b1;
                err_val = E_STATS;
              end
              if (idx_q == STAT_IW'(STAT_WORDS - 1)) begin
                idx_n = '0;
                st_n  = ST_SNAP_OFF;
              end else begin
                idx_n = idx_q + STAT_IW'(1);
              end
            end
            ST_SNAP_OFF: begin snap_n = 1'b0; st_n = ST_STOP; end
            ST_STOP:     st_n = ST_SCR_WR;
            ST_SCR_WR:   st_n = ST_SCR_RD;
            ST_SCR_RD: begin
              if (rsp_data != DW'(SCRATCH_PAT)) begin
                err_set = 1'b1;
                err_val = E_SCRATCH;
              end
              st_n = ST_DONE;
            end
            default: ;
          endcase
        end else if (tmr_exp) begin
          err_set = 1'b1;
          err_val = (st_q == ST_POLL) ? E_TRAFFIC : E_BUS;
          st_n    = ST_DONE;
        end else if (!pend_q) begin
          go     = 1'b1;
          pend_n = 1'b1;
        end
      end
    endcase
    tmr_clr = (st_n != st_q) || (st_q == ST_STATS && rsp_done);
  end

  // registers
  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      st_q   <= ST_RST;
      pend_q <= 1'b0;
      idx_q  <= '0;
      snap_q <= 1'b0;
      rel_q  <= 1'b0;
    end else begin
      st_q   <= st_n;
      pend_q <= pend_n;
      idx_q  <= idx_n;
      snap_q <= snap_n;
      rel_q  <= rel_n;
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n)                          err_q <= E_NONE;
    else if (err_set && err_q == E_NONE)  err_q <= err_val;
  end

  assign dp_rst_n = rel_q;
  assign done     = (st_q == ST_DONE);
  assign pass     = done && (err_q == E_NONE);
  assign err_code = err_q;

  // R1
  rst_release_after_ack_chk: assert property (@(posedge clk) disable iff (!srst_n)
    $rose(dp_rst_n) |-> $past(!dp_rst_ack_n));

  // R1
  no_bus_in_reset_chk: assert property (@(posedge clk) disable iff (!srst_n)
    !dp_rst_n |-> !(m_read || m_write));

  // R4
  stats_under_snapshot_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (m_read && m_address >= AW'(A_TX_BASE) && m_address <= AW'(A_STAT_LAST) &&
     m_address != AW'(A_TX_EOP_LO)) |-> snap_q);

  // R10
  done_sticky_chk: assert property (@(posedge clk) disable iff (!srst_n)
    done |=> done);

  // R10
  pass_clean_chk: assert property (@(posedge clk) disable iff (!srst_n)
    pass |-> (err_code == 3'd0) && done);

  // R10
  first_error_kept_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (err_code != 3'd0) |=> $stable(err_code));

endmodule

// File: tb/tb_eth_bist_seq.sv
module tb_eth_bist_seq;

  localparam int          CLK_NS = 10;
  localparam int          AW     = 12;
  localparam int          DW     = 32;
  localparam int          TW     = 16;
  localparam int          PKT    = 16;
  localparam logic [31:0] PAT    = 32'hA5C3_5A3C;
  localparam int          TLIM   = 300;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [TW-1:0] timeout_limit = TW'(TLIM);
  logic          dp_rst_n, ack_n, txs, rxr;
  logic [AW-1:0] m_address;
  logic          m_read, m_write, m_wait;
  logic [DW-1:0] m_writedata, m_rdata;
  logic          done, pass;
  logic [2:0]    err_code;

  always #(CLK_NS/2) clk = ~clk;

  eth_bist_seq #(.AW(AW), .DW(DW), .TW(TW), .PKT_COUNT(PKT), .SCRATCH_PAT(PAT)) dut (
    .clk(clk), .rst_n(rst_n), .timeout_limit(timeout_limit),
    .dp_rst_n(dp_rst_n), .dp_rst_ack_n(ack_n),
    .tx_lanes_stable(txs), .rx_pcs_ready(rxr),
    .m_address(m_address), .m_read(m_read), .m_write(m_write),
    .m_writedata(m_writedata), .m_readdata(m_rdata), .m_waitrequest(m_wait),
    .done(done), .pass(pass), .err_code(err_code)
  );

  // scenario knobs: fault 0 clean, 1 no ack, 2 no tx lanes (rx ready high),
  // 3 no rx ready, 4 short traffic, 5 rx error count, 6 scratch bit flip,
  // 7 bus stuck, 8 tx start-of-packet high word nonzero
  int k_stall = 0;
  int fault   = 0;

  // stub datapath and packet client
  logic [31:0] ctrl, scratch;
  logic [31:0] live [0:11];
  logic [31:0] snap [0:11];
  int          scnt, sent, gap, acnt, rcnt;
  logic        p_hold, p_rd, p_wr, p_dp, p_ack;
  logic [AW-1:0] p_addr;
  logic [DW-1:0] p_wd;
  int          v_hold, v_both, v_rst, v_snap, n_acc, n_wr, n_snaprd, n_poll;
  logic [AW-1:0] wl_addr [0:7];
  logic [31:0]   wl_data [0:7];
  logic        req;
  int          sidx;

  assign req    = m_read | m_write;
  assign m_wait = (fault == 7) ? 1'b1 : (req && (scnt < k_stall));
  assign sidx   = (int'(m_address) - 32) / 4;

  always_comb begin
    m_rdata = 32'd0;
    if (m_address == 12'h104)      m_rdata = scratch ^ ((fault == 6) ? 32'h10 : 32'h0);
    else if (m_address == 12'h000) m_rdata = ctrl;
    else if (m_address >= 12'h020 && m_address <= 12'h04C)
      m_rdata = ctrl[6] ? snap[sidx] : live[sidx];
  end

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl <= 0; scratch <= 0; scnt <= 0; sent <= 0; gap <= 0; acnt <= 0; rcnt <= 0;
      ack_n <= 1'b1; txs <= 1'b0; rxr <= (fault == 2);
      for (int i = 0; i < 12; i++) begin
        live[i] <= (fault == 8 && i == 1) ? 32'd1 : 32'd0;
        snap[i] <= 32'd0;
      end
      p_hold <= 0; p_rd <= 0; p_wr <= 0; p_addr <= 0; p_wd <= 0; p_dp <= 0; p_ack <= 1;
      v_hold <= 0; v_both <= 0; v_rst <= 0; v_snap <= 0;
      n_acc <= 0; n_wr <= 0; n_snaprd <= 0; n_poll <= 0;
    end else begin
      scnt <= (req && m_wait) ? scnt + 1 : 0;
      if (p_hold && (m_address != p_addr || m_writedata != p_wd ||
                     m_read != p_rd || m_write != p_wr)) v_hold <= v_hold + 1;
      p_hold <= req && m_wait; p_addr <= m_address; p_wd <= m_writedata;
      p_rd <= m_read; p_wr <= m_write;
      if (m_read && m_write) v_both <= v_both + 1;
      if (!p_dp && dp_rst_n && p_ack) v_rst <= v_rst + 1;
      p_dp <= dp_rst_n; p_ack <= ack_n;
      if (!dp_rst_n) begin
        acnt  <= acnt + 1;
        ack_n <= !(fault != 1 && acnt >= 2 + k_stall);
        rcnt <= 0; txs <= 1'b0; rxr <= (fault == 2);
      end else begin
        acnt <= 0; ack_n <= 1'b1; rcnt <= rcnt + 1;
        txs <= (fault != 2) && (rcnt >= 5);
        rxr <= (fault == 2) || ((fault != 3) && (rcnt >= 9));
      end
      if (ctrl[0] && sent < ((fault == 4) ? PKT - 1 : PKT)) begin
        if (gap == 7) begin
          gap <= 0; sent <= sent + 1;
          live[0] <= live[0] + 1; live[2] <= live[2] + 1;
          live[6] <= live[6] + 1; live[8] <= live[8] + 1;
          if (fault == 5) live[10] <= live[10] + 1;
        end else gap <= gap + 1;
      end
      if (req && !m_wait) begin
        n_acc <= n_acc + 1;
        if (m_write) begin
          if (n_wr < 8) begin wl_addr[n_wr] <= m_address; wl_data[n_wr] <= m_writedata; end
          n_wr <= n_wr + 1;
          if (m_address == 12'h000) begin
            if (m_writedata[6] && !ctrl[6])
              for (int i = 0; i < 12; i++) snap[i] <= live[i];
            ctrl <= m_writedata;
            if (m_writedata[8]) begin
              for (int i = 0; i < 12; i++) live[i] <= 32'd0;
              sent <= 0; gap <= 0;
            end
          end else if (m_address == 12'h104) scratch <= m_writedata;
        end else if (m_address == 12'h028 && !ctrl[6]) n_poll <= n_poll + 1;
        else if (m_address >= 12'h020 && m_address <= 12'h04C) begin
          if (ctrl[6]) n_snaprd <= n_snaprd + 1;
          else         v_snap <= v_snap + 1;
        end
      end
    end
  end

  int n_chk  = 0;
  int n_fail = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s k=%0d fault=%0d actual=0x%0h expected=0x%0h",
               tag, k_stall, fault, act, exp);
    end
  endtask

  function automatic int exp_err(input int f);
    case (f)
      1: return 1;  2: return 2;  3: return 3;  4: return 4;
      5: return 5;  6: return 6;  7: return 7;  8: return 5;
      default: return 0;
    endcase
  endfunction

  task automatic run(input int k, input int f);
    int  cyc, e;
    bit  full;
    string etag;
    k_stall = k; fault = f; rst_n = 1'b0;
    repeat (4) @(negedge clk);
    chk("R1 reset state", 32'({dp_rst_n, done, pass, m_read, m_write}), 32'd0);
    rst_n = 1'b1;
    cyc = 0;
    while (!done && cyc < 4000) begin @(negedge clk); cyc++; end
    e    = exp_err(f);
    full = (f == 0 || f == 5 || f == 6 || f == 8);
    etag = (f == 5 || f == 8) ? "R5 err_code" : (f == 6) ? "R7 err_code" :
           (f == 2) ? "R2 err_code" : (f == 0) ? "R10 err_code" : "R8 err_code";
    chk("R10 done", 32'(done), 32'd1);
    chk(etag, 32'(err_code), 32'(e));
    chk("R10 pass", 32'(pass), 32'(e == 0));
    chk("R1 released", 32'(dp_rst_n), 32'(f != 1));
    chk("R1 release order", 32'(v_rst), 32'd0);
    chk("R9 hold under stall", 32'(v_hold), 32'd0);
    chk("R9 no overlap", 32'(v_both), 32'd0);
    chk("R4 no read outside snapshot", 32'(v_snap), 32'd0);
    if (f == 2 || f == 3) chk("R2 no bus before ready", 32'(n_acc), 32'd0);
    chk("R3 write count", 32'(n_wr), full ? 32'd5 : (f == 4) ? 32'd1 : 32'd0);
    if (full || f == 4) begin
      chk("R3 start addr", 32'(wl_addr[0]), 32'h000);
      chk("R3 start data", wl_data[0], 32'h1);
      chk("R3 polled", 32'(n_poll >= 1), 32'd1);
    end
    if (full) begin
      chk("R4 snap on", wl_data[1], 32'h41);
      chk("R4 snap off", wl_data[2], 32'h1);
      chk("R4 snapshot reads", 32'(n_snaprd), 32'd12);
      chk("R6 stop data", wl_data[3], 32'h100);
      chk("R6 ctrl final", ctrl, 32'h100);
      chk("R6 counters cleared", live[2], 32'd0);
      chk("R7 scratch addr", 32'(wl_addr[4]), 32'h104);
      chk("R7 scratch data", wl_data[4], PAT);
    end
    repeat (3) @(negedge clk);
    chk("R10 done held", 32'({done, err_code}), 32'({1'b1, 3'(e)}));
  endtask

  initial begin
    for (int k = 0; k < 4; k++)
      for (int f = 0; f < 9; f++)
        run(k, f);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(CLK_NS * 200000);
    n_chk++;
    n_fail++;
    $display("FAIL R10 watchdog expired actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule